// File: doc/BRIEF.md
# Exception Classification and Entry Sequencer

This controller sits beside an in-order pipeline and decides when an exception is entered. Three groups of requests reach it. Instructions raise requests that carry their own address. Three interrupt lines can be masked: external, system-management and timer-decrement. Two lines cannot be masked: soft reset and machine check. In the cycle an exception is entered, the block stops the faulting instruction and every younger one from completing. It writes the restart address into save/restore register 0 and the current machine-state word into save/restore register 1. It then clears the external-enable bit, and for the two unmaskable sources it also clears the recoverable bit. One cycle later it shows the handler vector and a single-cycle flush.

A maskable interrupt waits until the instruction now in flight retires. If the pipeline is empty, it is entered at once and saves the next fetch address. A trap or system-call entry saves the address of the following instruction, which is where the handler resumes. Any other instruction fault saves the faulting address. A return-from-interrupt request reloads the machine-state word from save/restore register 1 and redirects fetch to save/restore register 0, both in one clock.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset the machine-state word is 0x03, meaning external-enable (bit 1) and recoverable (bit 0) are both set. Save/restore registers 0 and 1, `vector` and `exc_cls` are all zero, and `flush` and `resume` are low.
- R2: When several requests are present in one cycle, exactly one is entered. The order is reset, then machine check, then the instruction exception, then external, then system management, then decrementer.
- R3: An instruction fault (`sync_kind` 0 or 3) is entered in the cycle it is flagged, whatever the pipeline state. Save/restore register 0 then holds `sync_addr` and the vector offset is 0x300.
- R4: A trap (`sync_kind` 1) or system call (`sync_kind` 2) saves `sync_addr`+4 in save/restore register 0. Their vector offsets are 0x700 and 0xC00.
- R5: A maskable request is entered only when the external-enable bit is 1 and either `pipe_busy` is 0 or `retire` is 1. Otherwise it stays deferred with no effect. When entered it saves `next_pc`. The vector offsets are 0x500 for external, 0x1400 for system management and 0x900 for decrementer.
- R6: Reset and machine check are entered regardless of the enable bit and the pipeline state. They save `next_pc`, clear the recoverable bit and use vector offsets 0x100 and 0x200.
- R7: On every entry, save/restore register 1 receives the machine-state word from just before the entry, and the external-enable bit is cleared. The recoverable bit is kept for all sources except reset and machine check.
- R8: `flush` is high for exactly the cycle after an entry. In that cycle `vector` equals the offset and `exc_cls` gives the class: 0 for synchronous precise, 2 for asynchronous maskable, 3 for asynchronous nonmaskable. The value 1 (imprecise) never appears.
- R9: A `rfi` that is not displaced causes the following effects in the next cycle. The machine-state word equals save/restore register 1, `resume` pulses, and `resume_pc` holds save/restore register 0. `rfi` takes precedence over maskable requests. It is ignored, leaving `resume` low, when a nonmaskable or instruction exception is entered in the same cycle.
- R10: `commit_kill` is high, in the same cycle and combinationally, whenever `sync_req` is high or any exception is entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pipe_busy | input | 1 | An instruction occupies the execution units |
| retire | input | 1 | The in-flight instruction completes this cycle |
| next_pc | input | AW | Address of the oldest instruction that has not completed |
| sync_req | input | 1 | An instruction raises a precise exception |
| sync_kind | input | 2 | 0 or 3 fault, 1 trap, 2 system call |
| sync_addr | input | AW | Address of the instruction that raised the exception |
| ext_irq | input | 1 | External interrupt, maskable |
| smi_irq | input | 1 | System-management interrupt, maskable |
| dec_irq | input | 1 | Decrementer interrupt, maskable |
| sreset_req | input | 1 | Soft reset request, nonmaskable |
| mcheck_req | input | 1 | Machine check request, nonmaskable |
| rfi | input | 1 | Return-from-interrupt request |
| commit_kill | output | 1 | Stops completion of the current and younger instructions |
| flush | output | 1 | Single-cycle pipeline flush after an entry |
| vector | output | AW | Handler address of the last entry |
| exc_cls | output | 2 | Class of the last entry |
| resume | output | 1 | Single-cycle pulse that redirects fetch after a return |
| resume_pc | output | AW | Fetch target for the return |
| srr0 | output | AW | Save/restore register 0 (restart address) |
| srr1 | output | MW | Save/restore register 1 (saved machine-state word) |
| msr | output | MW | Machine-state word |

## Verification
The interesting coincidences are a return-from-interrupt arriving in the same cycle as an exception request, and several exception sources arriving together. The bench holds an external request high across a return. It expects the return to win and the interrupt to enter in the cycle after, once the restored enable bit applies. It also raises a return together with an instruction fault and expects the fault to enter with no `resume` pulse. Stacked requests of every priority level are judged against a behavioural model that is compared on every clock.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef enum logic [3:0] {
    SRC_NONE  = 4'd0,
    SRC_RESET = 4'd1,
    SRC_MCHK  = 4'd2,
    SRC_FAULT = 4'd3,
    SRC_TRAP  = 4'd4,
    SRC_SYSC  = 4'd5,
    SRC_EXT   = 4'd6,
    SRC_SMI   = 4'd7,
    SRC_DEC   = 4'd8
  } exc_src_e;

  typedef enum logic [1:0] {
    CLS_SYNC_PRECISE   = 2'd0,
    CLS_SYNC_IMPRECISE = 2'd1,
    CLS_ASYNC_MASK     = 2'd2,
    CLS_ASYNC_NMI      = 2'd3
  } exc_cls_e;

  localparam int unsigned OFS_W = 16;

  function automatic logic [OFS_W-1:0] vec_offset(exc_src_e s);
    case (s)
      SRC_RESET: return 16'h0100;
      SRC_MCHK:  return 16'h0200;
      SRC_FAULT: return 16'h0300;
      SRC_EXT:   return 16'h0500;
      SRC_TRAP:  return 16'h0700;
      SRC_DEC:   return 16'h0900;
      SRC_SYSC:  return 16'h0C00;
      SRC_SMI:   return 16'h1400;
      default:   return 16'h0000;
    endcase
  endfunction

  function automatic logic is_nmi(exc_src_e s);
    return (s == SRC_RESET) || (s == SRC_MCHK);
  endfunction

  function automatic exc_cls_e cls_of(exc_src_e s);
    case (s)
      SRC_RESET, SRC_MCHK:         return CLS_ASYNC_NMI;
      SRC_EXT, SRC_SMI, SRC_DEC:   return CLS_ASYNC_MASK;
      default:                     return CLS_SYNC_PRECISE;
    endcase
  endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
(
  input  logic       msr_ee,
  input  logic       pipe_busy,
  input  logic       retire,
  input  logic       sync_req,
  input  logic [1:0] sync_kind,
  input  logic       ext_irq,
  input  logic       smi_irq,
  input  logic       dec_irq,
  input  logic       sreset_req,
  input  logic       mcheck_req,
  input  logic       rfi,
  output exc_src_e   take_src,
  output logic       take,
  output logic       rfi_go
);

  logic async_ok;

  always_comb begin
    async_ok = msr_ee & (~pipe_busy | retire);
    take_src = SRC_NONE;
    if (sreset_req)      take_src = SRC_RESET;
    else if (mcheck_req) take_src = SRC_MCHK;
    else if (sync_req) begin
      case (sync_kind)
        2'd1:    take_src = SRC_TRAP;
        2'd2:    take_src = SRC_SYSC;
        default: take_src = SRC_FAULT;
      endcase
    end
    else if (rfi)        take_src = SRC_NONE;
    else if (async_ok) begin
      if (ext_irq)       take_src = SRC_EXT;
      else if (smi_irq)  take_src = SRC_SMI;
      else if (dec_irq)  take_src = SRC_DEC;
    end
  end

  assign take   = (take_src != SRC_NONE);
  assign rfi_go = rfi & ~take;

endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
  import exc_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter int unsigned MW         = 8,
  parameter int unsigned EE_BIT     = 1,
  parameter int unsigned RI_BIT     = 0,
  parameter logic [MW-1:0] MSR_RESET = 8'h03,
  parameter int unsigned INSN_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  exc_src_e      take_src,
  input  logic          rfi_go,
  input  logic [AW-1:0] sync_addr,
  input  logic [AW-1:0] next_pc,
  output logic [AW-1:0] srr0,
  output logic [MW-1:0] srr1,
  output logic [MW-1:0] msr
);

  function automatic logic [AW-1:0] restart_addr(exc_src_e s, logic [AW-1:0] fa,
                                                 logic [AW-1:0] np);
    case (s)
      SRC_FAULT:          return fa;
      SRC_TRAP, SRC_SYSC: return fa + AW'(INSN_BYTES);
      default:            return np;
    endcase
  endfunction

  function automatic logic [MW-1:0] entry_msr(logic [MW-1:0] m, exc_src_e s);
    logic [MW-1:0] r;
    r = m;
    r[EE_BIT] = 1'b0;
    if (is_nmi(s)) r[RI_BIT] = 1'b0;
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      srr0 <= '0;
      srr1 <= '0;
      msr  <= MSR_RESET;
    end else if (take) begin
      srr0 <= restart_addr(take_src, sync_addr, next_pc);
      srr1 <= msr;
      msr  <= entry_msr(msr, take_src);
    end else if (rfi_go) begin
      msr  <= srr1;
    end
  end

endmodule

// File: rtl/exc_redirect.sv
module exc_redirect
  import exc_pkg::*;
#(
  parameter int unsigned   AW       = 32,
  parameter logic [AW-1:0] VEC_BASE = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  exc_src_e      take_src,
  input  logic          rfi_go,
  input  logic [AW-1:0] srr0,
  output logic          flush,
  output logic [AW-1:0] vector,
  output exc_cls_e      cls,
  output logic          resume,
  output logic [AW-1:0] resume_pc
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flush     <= 1'b0;
      vector    <= '0;
      cls       <= CLS_SYNC_PRECISE;
      resume    <= 1'b0;
      resume_pc <= '0;
    end else begin
      flush  <= take;
      resume <= rfi_go;
      if (take) begin
        vector <= VEC_BASE + AW'(vec_offset(take_src));
        cls    <= cls_of(take_src);
      end
      if (rfi_go) resume_pc <= srr0;
    end
  end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter int unsigned   AW         = 32,
  parameter int unsigned   MW         = 8,
  parameter int unsigned   EE_BIT     = 1,
  parameter int unsigned   RI_BIT     = 0,
  parameter logic [MW-1:0] MSR_RESET  = 8'h03,
  parameter int unsigned   INSN_BYTES = 4,
  parameter logic [AW-1:0] VEC_BASE   = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pipe_busy,
  input  logic          retire,
  input  logic [AW-1:0] next_pc,
  input  logic          sync_req,
  input  logic [1:0]    sync_kind,
  input  logic [AW-1:0] sync_addr,
  input  logic          ext_irq,
  input  logic          smi_irq,
  input  logic          dec_irq,
  input  logic          sreset_req,
  input  logic          mcheck_req,
  input  logic          rfi,
  output logic          commit_kill,
  output logic          flush,
  output logic [AW-1:0] vector,
  output logic [1:0]    exc_cls,
  output logic          resume,
  output logic [AW-1:0] resume_pc,
  output logic [AW-1:0] srr0,
  output logic [MW-1:0] srr1,
  output logic [MW-1:0] msr
);

  exc_src_e take_src;
  logic     take;
  logic     rfi_go;
  exc_cls_e cls_q;

  exc_arbiter u_arb (
    .msr_ee     (msr[EE_BIT]),
    .pipe_busy  (pipe_busy),
    .retire     (retire),
    .sync_req   (sync_req),
    .sync_kind  (sync_kind),
    .ext_irq    (ext_irq),
    .smi_irq    (smi_irq),
    .dec_irq    (dec_irq),
    .sreset_req (sreset_req),
    .mcheck_req (mcheck_req),
    .rfi        (rfi),
    .take_src   (take_src),
    .take       (take),
    .rfi_go     (rfi_go)
  );

  exc_state_regs #(
    .AW(AW), .MW(MW), .EE_BIT(EE_BIT), .RI_BIT(RI_BIT),
    .MSR_RESET(MSR_RESET), .INSN_BYTES(INSN_BYTES)
  ) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .take_src  (take_src),
    .rfi_go    (rfi_go),
    .sync_addr (sync_addr),
    .next_pc   (next_pc),
    .srr0      (srr0),
    .srr1      (srr1),
    .msr       (msr)
  );

  exc_redirect #(.AW(AW), .VEC_BASE(VEC_BASE)) u_redir (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .take_src  (take_src),
    .rfi_go    (rfi_go),
    .srr0      (srr0),
    .flush     (flush),
    .vector    (vector),
    .cls       (cls_q),
    .resume    (resume),
    .resume_pc (resume_pc)
  );

  assign commit_kill = sync_req | take;
  assign exc_cls     = cls_q;

endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
  parameter int unsigned MW     = 8,
  parameter int unsigned EE_BIT = 1,
  parameter int unsigned RI_BIT = 0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sync_req,
  input logic          commit_kill,
  input logic          flush,
  input logic [1:0]    exc_cls,
  input logic          resume,
  input logic [MW-1:0] srr1,
  input logic [MW-1:0] msr
);

  // R10
  kill_on_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_req |-> commit_kill);

  // R7
  ee_off_after_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !msr[EE_BIT]);

  // R5
  mask_needs_ee_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && exc_cls == 2'd2) |-> $past(msr[EE_BIT]));

  // R6
  nmi_clears_ri_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && exc_cls == 2'd3) |-> !msr[RI_BIT]);

  // R9
  rfi_restores_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume |-> (msr == $past(srr1)));

  // R9
  resume_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume |-> !flush);

  // R8
  no_imprecise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_cls != 2'd1);

endmodule

bind exc_entry_seq exc_entry_seq_chk #(.MW(MW), .EE_BIT(EE_BIT), .RI_BIT(RI_BIT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sync_req    (sync_req),
  .commit_kill (commit_kill),
  .flush       (flush),
  .exc_cls     (exc_cls),
  .resume      (resume),
  .srr1        (srr1),
  .msr         (msr)
);

// File: tb/exc_entry_seq_bench.sv
module exc_entry_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pipe_busy, retire, sync_req, ext_irq, smi_irq, dec_irq;
  logic        sreset_req, mcheck_req, rfi;
  logic [1:0]  sync_kind;
  logic [31:0] next_pc, sync_addr;
  logic        commit_kill, flush, resume;
  logic [31:0] vector, resume_pc, srr0;
  logic [1:0]  exc_cls;
  logic [7:0]  srr1, msr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  logic [31:0] m_srr0, m_vec, m_rpc;
  logic [7:0]  m_srr1, m_msr;
  logic        m_flush, m_res;
  logic [1:0]  m_cls;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_seq u_exc_entry_seq (
    .clk(clk), .rst_n(rst_n), .pipe_busy(pipe_busy), .retire(retire),
    .next_pc(next_pc), .sync_req(sync_req), .sync_kind(sync_kind),
    .sync_addr(sync_addr), .ext_irq(ext_irq), .smi_irq(smi_irq),
    .dec_irq(dec_irq), .sreset_req(sreset_req), .mcheck_req(mcheck_req),
    .rfi(rfi), .commit_kill(commit_kill), .flush(flush), .vector(vector),
    .exc_cls(exc_cls), .resume(resume), .resume_pc(resume_pc),
    .srr0(srr0), .srr1(srr1), .msr(msr)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_srr0 = 0; m_srr1 = 0; m_msr = 8'h03; m_flush = 0; m_res = 0;
    m_vec = 0; m_cls = 0; m_rpc = 0;
  endtask

  task automatic compare_all();
    chk(flush == m_flush, "R8 flush", {31'd0, flush}, {31'd0, m_flush});
    chk(vector == m_vec, "R2 vector", vector, m_vec);
    chk(exc_cls == m_cls, "R8 exc_cls", {30'd0, exc_cls}, {30'd0, m_cls});
    chk(srr0 == m_srr0, "R3 srr0", srr0, m_srr0);
    chk(srr1 == m_srr1, "R7 srr1", {24'd0, srr1}, {24'd0, m_srr1});
    chk(msr == m_msr, "R9 msr", {24'd0, msr}, {24'd0, m_msr});
    chk(resume == m_res, "R9 resume", {31'd0, resume}, {31'd0, m_res});
    chk(resume_pc == m_rpc, "R9 resume_pc", resume_pc, m_rpc);
  endtask

  function automatic logic [31:0] ofs_of(int p);
    case (p)
      1: return 32'h100;  2: return 32'h200;  3: return 32'h300;
      4: return 32'h700;  5: return 32'hC00;  6: return 32'h500;
      7: return 32'h1400; 8: return 32'h900;
      default: return 32'h0;
    endcase
  endfunction

  // one clock: drive at negedge, check comb, advance model at posedge, compare at negedge
  task automatic step(input logic bz, input logic rt, input logic [31:0] np,
                      input logic sq, input logic [1:0] sk, input logic [31:0] sa,
                      input logic e, input logic s, input logic d,
                      input logic rs, input logic mc, input logic rf);
    int pick;
    logic ok_async;
    pipe_busy = bz; retire = rt; next_pc = np; sync_req = sq; sync_kind = sk;
    sync_addr = sa; ext_irq = e; smi_irq = s; dec_irq = d;
    sreset_req = rs; mcheck_req = mc; rfi = rf;
    #1;
    ok_async = m_msr[1] && (!bz || rt);
    pick = 0;
    if (rs) pick = 1;
    else if (mc) pick = 2;
    else if (sq) pick = (sk == 2'd1) ? 4 : ((sk == 2'd2) ? 5 : 3);
    else if (!rf && ok_async) pick = e ? 6 : (s ? 7 : (d ? 8 : 0));
    chk(commit_kill == (sq || pick != 0), "R10 commit_kill",
        {31'd0, commit_kill}, {31'd0, (sq || pick != 0)});
    @(posedge clk);
    if (pick != 0) begin
      m_srr0  = (pick == 3) ? sa : ((pick == 4 || pick == 5) ? sa + 32'd4 : np);
      m_srr1  = m_msr;
      m_msr   = m_msr & 8'hFD;
      if (pick <= 2) m_msr = m_msr & 8'hFE;
      m_flush = 1; m_vec = ofs_of(pick);
      m_cls   = (pick <= 2) ? 2'd3 : ((pick <= 5) ? 2'd0 : 2'd2);
      m_res   = 0;
    end else if (rf) begin
      m_msr = m_srr1; m_res = 1; m_rpc = m_srr0; m_flush = 0;
    end else begin
      m_flush = 0; m_res = 0;
    end
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    step(0, 0, 32'h0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic do_rfi();
    step(0, 0, 32'h0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 0;
    {pipe_busy, retire, sync_req, ext_irq, smi_irq, dec_irq} = '0;
    {sreset_req, mcheck_req, rfi} = '0;
    sync_kind = 0; next_pc = 0; sync_addr = 0;
    repeat (2) @(negedge clk);
    model_reset();
    // R1 reset state
    chk(msr == 8'h03, "R1 msr", {24'd0, msr}, 32'h03);
    chk(srr0 == 0 && srr1 == 0, "R1 srr", srr0, 32'h0);
    chk(!flush && !resume, "R1 pulses", {30'd0, flush, resume}, 32'h0);
    chk(vector == 0 && exc_cls == 0, "R1 vector", vector, 32'h0);
    rst_n = 1;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    apply_reset();
    step(1, 0, 32'h3C, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R5 deferred while busy without retire
    step(1, 0, 32'h40, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    chk(flush == 0, "R5 deferred busy", {31'd0, flush}, 32'h0);
    step(1, 1, 32'h44, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    chk(flush && vector == 32'h500 && srr0 == 32'h44, "R5 ext taken", vector, 32'h500);
    chk(msr == 8'h01 && srr1 == 8'h03, "R7 ee cleared", {24'd0, msr}, 32'h01);
    // R5 masked while EE off; R8 flush dropped
    step(0, 0, 32'h44, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    chk(flush == 0, "R5 masked", {31'd0, flush}, 32'h0);
    // R9 rfi beats maskable in the same cycle
    step(0, 0, 32'h44, 0, 0, 0, 1, 0, 0, 0, 0, 1);
    chk(resume && resume_pc == 32'h44 && msr == 8'h03 && !flush, "R9 rfi wins",
        resume_pc, 32'h44);
    step(0, 0, 32'h48, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    chk(flush && srr0 == 32'h48, "R5 ext after rfi", srr0, 32'h48);
    do_rfi();
    // R3 fault
    step(1, 0, 32'h1004, 1, 2'd0, 32'h1000, 0, 0, 0, 0, 0, 0);
    chk(srr0 == 32'h1000 && vector == 32'h300 && exc_cls == 0, "R3 fault", srr0, 32'h1000);
    do_rfi();
    // R4 trap and system call
    step(1, 0, 32'h2008, 1, 2'd1, 32'h2000, 0, 0, 0, 0, 0, 0);
    chk(srr0 == 32'h2004 && vector == 32'h700, "R4 trap", srr0, 32'h2004);
    do_rfi();
    step(1, 0, 32'h3008, 1, 2'd2, 32'h3000, 0, 0, 0, 0, 0, 0);
    chk(srr0 == 32'h3004 && vector == 32'hC00, "R4 syscall", srr0, 32'h3004);
    do_rfi();
    // R2 priority ladder
    step(0, 0, 32'h80, 1, 2'd0, 32'h90, 1, 1, 1, 1, 1, 1);
    chk(vector == 32'h100 && exc_cls == 3, "R2 reset first", vector, 32'h100);
    chk(msr == 8'h00, "R6 reset clears ri", {24'd0, msr}, 32'h0);
    do_rfi();
    step(0, 0, 32'h84, 1, 2'd0, 32'h94, 1, 0, 0, 0, 1, 0);
    chk(vector == 32'h200, "R2 mcheck second", vector, 32'h200);
    do_rfi();
    step(0, 0, 32'h88, 1, 2'd1, 32'h98, 1, 1, 0, 0, 0, 0);
    chk(vector == 32'h700, "R2 sync over ext", vector, 32'h700);
    do_rfi();
    step(0, 0, 32'h8C, 0, 0, 0, 0, 1, 1, 0, 0, 0);
    chk(vector == 32'h1400 && exc_cls == 2, "R2 smi over dec", vector, 32'h1400);
    do_rfi();
    step(0, 0, 32'h8C, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk(vector == 32'h900, "R5 dec", vector, 32'h900);
    do_rfi();
    step(0, 0, 32'h8C, 0, 0, 0, 1, 1, 1, 0, 0, 0);
    chk(vector == 32'h500, "R2 ext over smi", vector, 32'h500);
    do_rfi();
    // R6 machine check ignores EE and busy
    step(1, 0, 32'hA4, 1, 2'd0, 32'hA0, 0, 0, 0, 0, 0, 0);
    step(1, 0, 32'hA4, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    chk(flush && vector == 32'h200 && srr1 == 8'h01 && msr == 8'h00, "R6 mcheck",
        {24'd0, msr}, 32'h0);
    idle();
    chk(flush == 0, "R8 single pulse", {31'd0, flush}, 32'h0);
    // R9 rfi displaced by a fault
    step(1, 0, 32'hB4, 1, 2'd0, 32'hB0, 0, 0, 0, 0, 0, 1);
    chk(!resume && flush && srr0 == 32'hB0, "R9 rfi ignored", {31'd0, resume}, 32'h0);
    idle();
    apply_reset();
    idle();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule